// File: doc/BRIEF.md
# Execute-in-Place Flash Read Cache

This block sits between a processor fetch port and the line-fill interface of an external serial flash, so that code and constant data can run directly out of flash. It covers a 16 MB flash window (24-bit byte address) and keeps 32 KB of copies in 128 sets of 8 ways, each way holding a 32-byte line of eight 32-bit words. A miss fetches one aligned line as a burst and replaces a way chosen by a per-set binary-tree pseudo-LRU, always taking an empty way first.

Three control inputs select how a request is served. With the cache enabled, reads look up the tags. With it disabled, every read goes straight to flash as a single-word fetch and the cached contents are left alone. With the scratch-memory mode selected, the data array is read and written as plain 32 KB memory and the tags play no part. A flush pulse clears every line, one set per cycle, and holds off new requests until it is done. The serial protocol itself is outside the block: it is represented by a request pulse carrying an address and a burst flag, answered by a stream of words.

Top module: `xip_flash_cache`

## Requirements
- R1: After reset `reqReady` is 1, `respValid` and `fillReq` are 0, and every line is invalid, so the first cached read misses.
- R2: A cached read splits the byte address into offset [4:0], set [11:5] and tag [23:12]; when a valid way of the set holds the tag, `respValid` pulses for one cycle on the second rising edge after the accepting edge with the stored word, and no `fillReq` is issued.
- R3: A cached read that misses pulses `fillReq` for one cycle on the second edge after acceptance with `fillBurst`=1 and `fillAddr` equal to the address with bits [4:0] cleared; the eight words arrive on `fillDataValid` in ascending offset order, possibly with idle cycles between them, and the requested word is returned with `respValid` on the edge after the eighth word, after which the line is resident.
- R4: A miss fills the lowest-numbered invalid way of the set before any valid way is evicted, so eight distinct tags in one set all stay resident.
- R5: When all eight ways are valid the victim is chosen by a 7-node tree per set (node 0 the root, node n has children 2n+1 and 2n+2, bit 0 selects the subtree of lower-numbered ways, bit 1 the upper); every hit and fill sets each node on the path of the accessed way to point away from it. The tree is zero after reset.
- R6: With `cacheEn`=0 and `sramMode`=0, every read issues `fillReq` with `fillBurst`=0 and `fillAddr` equal to the address with bits [1:0] cleared, and returns the single word received on the edge after it arrives; cached lines are not changed.
- R7: With `sramMode`=1 (overriding `cacheEn`) address bits [14:5] select an array line and bits [4:2] a word in it, upper bits are ignored; writes store `reqWdata`, reads return the last word stored, both respond with `respValid` on the second edge after acceptance with `respErr`=0, and no `fillReq` is issued. A write response carries data 0.
- R8: A write with `sramMode`=0 is ignored: it responds on the second edge after acceptance with `respErr`=1 and `respData`=0, issues no `fillReq`, and a later read of the same resident line still hits with the original word.
- R9: A one-cycle `flushReq` drops `reqReady` from the next cycle, clears every valid bit, and `reqReady` returns within 130 cycles once no request is in progress; a flush that arrives during a line fill waits for that fill's response. Every read afterwards misses.
- R10: Only one request is outstanding: `reqReady` is 0 from the accepting edge until the response, and `respValid` and `fillReq` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cacheEn | input | 1 | 1 = cached reads, 0 = reads bypass to flash |
| sramMode | input | 1 | 1 = data array used as plain memory |
| flushReq | input | 1 | Pulse to invalidate every line |
| reqValid | input | 1 | Fetch request present |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| reqWrite | input | 1 | 1 = write request |
| reqAddr | input | 24 | Byte address |
| reqWdata | input | 32 | Write data |
| respValid | output | 1 | One-cycle response strobe |
| respData | output | 32 | Read data |
| respErr | output | 1 | Ignored write |
| fillReq | output | 1 | One-cycle flash fetch request |
| fillBurst | output | 1 | 1 = eight-word line, 0 = one word |
| fillAddr | output | 24 | Flash byte address of the fetch |
| fillDataValid | input | 1 | Flash word valid |
| fillData | input | 32 | Flash word |

## Verification
The bench keeps its own model of tags, valid bits and trees and predicts, for each read, hit or miss and the victim; a design that walked the tree the wrong way or forgot to touch it on hits would evict a different way and turn a predicted hit into a fill request. It fills one set with eight tags and then keeps missing and re-reading it, which exposes a design that evicts a valid way while an invalid one remains. Fills are served with and without idle cycles between words, so a design that counts cycles rather than valid words returns the wrong word, and a flush raised in the middle of a fill checks that the flush neither cuts the fill short nor lets a new request in. Writes outside scratch mode, bypass reads of resident lines and aliased scratch addresses check that these paths leave the array and tags untouched.

// File: rtl/xipc_pkg.sv
package xipc_pkg;

  typedef enum logic [1:0] {
    MODE_CACHE  = 2'd0,
    MODE_BYPASS = 2'd1,
    MODE_SRAM   = 2'd2
  } accMode_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ARRAY = 2'd1,
    SRC_LINE  = 2'd2,
    SRC_FLASH = 2'd3
  } rspSrc_e;

  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic    latchReq;
    logic    sramSel;
    logic    hitTouch;
    logic    lineWr;
    logic    sramWr;
    logic    fillCapture;
    logic    flushClr;
    logic    respLoad;
    rspSrc_e respSrc;
  } dpStrobe_t;

endpackage

// File: rtl/xipc_ctrl.sv
module xipc_ctrl
  import xipc_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int WORDS = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cacheEn,
  input  logic                    sramMode,
  input  logic                    flushReq,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  output logic                    reqReady,
  input  logic                    hit,
  input  logic                    fillDataValid,
  output logic                    fillReq,
  output logic                    fillBurst,
  output logic                    respValid,
  output logic                    respErr,
  output dpStrobe_t               stb,
  output logic [$clog2(SETS)-1:0] flushIdx
);
  localparam int IDX_BITS  = $clog2(SETS);
  localparam int WCNT_BITS = $clog2(WORDS);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL, ST_FLUSH} state_e;

  state_e                state, stateNext;
  accMode_e              modeQ;
  logic                  wrQ;
  logic                  flushPend;
  logic [WCNT_BITS-1:0]  wordCnt;
  logic [IDX_BITS-1:0]   flushCnt;
  logic                  issueFill, issueBurst, respSet, errSet;
  logic                  lastWord;

  assign reqReady = (state == ST_IDLE) && !flushPend;
  assign flushIdx = flushCnt;
  assign lastWord = fillBurst ? (wordCnt == WCNT_BITS'(WORDS - 1)) : 1'b1;

  always_comb begin
    stb         = '0;
    stb.sramSel = (modeQ == MODE_SRAM);
    stateNext   = state;
    issueFill   = 1'b0;
    issueBurst  = 1'b0;
    respSet     = 1'b0;
    errSet      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (flushPend) begin
          stateNext = ST_FLUSH;
        end else if (reqValid) begin
          stb.latchReq = 1'b1;
          stateNext    = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (modeQ == MODE_SRAM) begin
          stb.sramWr   = wrQ;
          stb.respLoad = 1'b1;
          stb.respSrc  = wrQ ? SRC_NONE : SRC_ARRAY;
          respSet      = 1'b1;
          stateNext    = ST_IDLE;
        end else if (wrQ) begin
          stb.respLoad = 1'b1;
          stb.respSrc  = SRC_NONE;
          respSet      = 1'b1;
          errSet       = 1'b1;
          stateNext    = ST_IDLE;
        end else if ((modeQ == MODE_CACHE) && hit) begin
          stb.hitTouch = 1'b1;
          stb.respLoad = 1'b1;
          stb.respSrc  = SRC_ARRAY;
          respSet      = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          issueFill  = 1'b1;
          issueBurst = (modeQ == MODE_CACHE);
          stateNext  = ST_FILL;
        end
      end
      ST_FILL: begin
        if (fillDataValid) begin
          stb.fillCapture = fillBurst;
          if (lastWord) begin
            stb.lineWr   = fillBurst;
            stb.respLoad = 1'b1;
            stb.respSrc  = fillBurst ? SRC_LINE : SRC_FLASH;
            respSet      = 1'b1;
            stateNext    = ST_IDLE;
          end
        end
      end
      ST_FLUSH: begin
        stb.flushClr = 1'b1;
        if (flushCnt == IDX_BITS'(SETS - 1)) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      modeQ     <= MODE_CACHE;
      wrQ       <= 1'b0;
      flushPend <= 1'b0;
      wordCnt   <= '0;
      flushCnt  <= '0;
      fillReq   <= 1'b0;
      fillBurst <= 1'b0;
      respValid <= 1'b0;
      respErr   <= 1'b0;
    end else begin
      state     <= stateNext;
      fillReq   <= issueFill;
      respValid <= respSet;
      respErr   <= errSet;
      flushPend <= flushReq | (flushPend & (state != ST_IDLE));
      if (stb.latchReq) begin
        modeQ <= sramMode ? MODE_SRAM : (cacheEn ? MODE_CACHE : MODE_BYPASS);
        wrQ   <= reqWrite;
      end
      if (issueFill) begin
        fillBurst <= issueBurst;
        wordCnt   <= '0;
      end else if ((state == ST_FILL) && fillDataValid) begin
        wordCnt <= wordCnt + 1'b1;
      end
      if ((state == ST_IDLE) && (stateNext == ST_FLUSH)) flushCnt <= '0;
      else if (state == ST_FLUSH) flushCnt <= flushCnt + 1'b1;
    end
  end

endmodule

// File: rtl/xipc_datapath.sv
module xipc_datapath
  import xipc_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 8,
  parameter int SETS       = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               stb,
  input  logic [$clog2(SETS)-1:0] flushIdx,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [DATA_W-1:0]       fillData,
  input  logic                    fillBurst,
  output logic                    hit,
  output logic [ADDR_W-1:0]       fillAddr,
  output logic [DATA_W-1:0]       respData
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int BYTE_BITS  = $clog2(WORD_BYTES);
  localparam int WSEL_BITS  = $clog2(WORDS);
  localparam int OFF_BITS   = $clog2(LINE_BYTES);
  localparam int IDX_BITS   = $clog2(SETS);
  localparam int WAY_BITS   = $clog2(WAYS);
  localparam int TAG_BITS   = ADDR_W - IDX_BITS - OFF_BITS;
  localparam int ENT_BITS   = IDX_BITS + WAY_BITS;
  localparam int ENTRIES    = SETS * WAYS;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int TREE_BITS  = WAYS - 1;
  localparam int WA_BITS    = ADDR_W - BYTE_BITS;

  // Walk the tree from the root, following each node's bit.
  function automatic logic [WAY_BITS-1:0] plruVictim(input logic [TREE_BITS-1:0] t);
    int                  node;
    logic                b;
    logic [WAY_BITS-1:0] way;
    node = 0;
    way  = '0;
    for (int l = 0; l < WAY_BITS; l++) begin
      b    = t[node];
      way  = (way << 1) | WAY_BITS'(b);
      node = 2 * node + 1 + int'(b);
    end
    return way;
  endfunction

  // Point every node on the path of way w away from it.
  function automatic logic [TREE_BITS-1:0] plruTouch(input logic [TREE_BITS-1:0] t,
                                                     input logic [WAY_BITS-1:0]  w);
    int                   node;
    logic                 b;
    logic [TREE_BITS-1:0] res;
    node = 0;
    res  = t;
    for (int l = 0; l < WAY_BITS; l++) begin
      b         = w[WAY_BITS-1-l];
      res[node] = ~b;
      node      = 2 * node + 1 + int'(b);
    end
    return res;
  endfunction

  logic [WA_BITS-1:0]   addrQ;
  logic [DATA_W-1:0]    wdataQ;
  logic                 unusedLow;
  logic [TAG_BITS-1:0]  tagF;
  logic [IDX_BITS-1:0]  idxF;
  logic [WSEL_BITS-1:0] wordF;
  logic [ENT_BITS-1:0]  sramEnt, rdEnt;

  logic [LINE_BITS-1:0] dataMem [ENTRIES];
  logic [TAG_BITS-1:0]  tagMem  [ENTRIES];
  logic [WAYS-1:0]      validQ  [SETS];
  logic [TREE_BITS-1:0] plruQ   [SETS];

  logic [WAYS-1:0]      hitVec;
  logic [WAY_BITS-1:0]  hitWay, freeWay, victWay;
  logic [LINE_BITS-1:0] lineBuf, lineNext;
  logic [WSEL_BITS-1:0] fillPtr;
  logic [DATA_W-1:0]    arrayWord, lineWord;

  assign unusedLow = ^reqAddr[BYTE_BITS-1:0];
  assign tagF      = addrQ[WA_BITS-1 -: TAG_BITS];
  assign idxF      = addrQ[WSEL_BITS +: IDX_BITS];
  assign wordF     = addrQ[WSEL_BITS-1:0];
  assign sramEnt   = addrQ[WSEL_BITS +: ENT_BITS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w] = validQ[idxF][w] && (tagMem[{idxF, WAY_BITS'(w)}] == tagF);
  end

  assign hit = |hitVec;

  always_comb begin
    hitWay  = '0;
    freeWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_BITS'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validQ[idxF][w]) freeWay = WAY_BITS'(w);
    end
    victWay = (&validQ[idxF]) ? plruVictim(plruQ[idxF]) : freeWay;
  end

  always_comb begin
    lineNext = lineBuf;
    lineNext[fillPtr*DATA_W +: DATA_W] = fillData;
  end

  assign rdEnt     = stb.sramSel ? sramEnt : {idxF, hitWay};
  assign arrayWord = dataMem[rdEnt][wordF*DATA_W +: DATA_W];
  assign lineWord  = lineNext[wordF*DATA_W +: DATA_W];
  assign fillAddr  = fillBurst ? {addrQ[WA_BITS-1:WSEL_BITS], OFF_BITS'(0)}
                               : {addrQ, BYTE_BITS'(0)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      lineBuf  <= '0;
      fillPtr  <= '0;
      respData <= '0;
    end else begin
      if (stb.latchReq) begin
        addrQ   <= reqAddr[ADDR_W-1:BYTE_BITS];
        wdataQ  <= reqWdata;
        fillPtr <= '0;
      end
      if (stb.fillCapture) begin
        lineBuf <= lineNext;
        fillPtr <= fillPtr + 1'b1;
      end
      if (stb.respLoad) begin
        unique case (stb.respSrc)
          SRC_ARRAY: respData <= arrayWord;
          SRC_LINE:  respData <= lineWord;
          SRC_FLASH: respData <= fillData;
          default:   respData <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.lineWr) begin
      dataMem[{idxF, victWay}] <= lineNext;
      tagMem[{idxF, victWay}]  <= tagF;
    end else if (stb.sramWr) begin
      dataMem[sramEnt][wordF*DATA_W +: DATA_W] <= wdataQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        plruQ[s]  <= '0;
      end
    end else begin
      if (stb.flushClr) validQ[flushIdx] <= '0;
      if (stb.lineWr) begin
        validQ[idxF][victWay] <= 1'b1;
        plruQ[idxF]           <= plruTouch(plruQ[idxF], victWay);
      end else if (stb.hitTouch) begin
        plruQ[idxF] <= plruTouch(plruQ[idxF], hitWay);
      end
    end
  end

endmodule

// File: rtl/xip_flash_cache.sv
module xip_flash_cache
  import xipc_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 8,
  parameter int SETS       = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheEn,
  input  logic              sramMode,
  input  logic              flushReq,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              respErr,
  output logic              fillReq,
  output logic              fillBurst,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillDataValid,
  input  logic [DATA_W-1:0] fillData
);
  localparam int WORDS    = LINE_BYTES / (DATA_W / 8);
  localparam int IDX_BITS = $clog2(SETS);

  dpStrobe_t           stb;
  logic                hit;
  logic [IDX_BITS-1:0] flushIdx;

  xipc_ctrl #(.SETS(SETS), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .sramMode(sramMode),
    .flushReq(flushReq), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .hit(hit), .fillDataValid(fillDataValid),
    .fillReq(fillReq), .fillBurst(fillBurst), .respValid(respValid),
    .respErr(respErr), .stb(stb), .flushIdx(flushIdx)
  );

  xipc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES),
    .WAYS(WAYS), .SETS(SETS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .flushIdx(flushIdx),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .fillData(fillData),
    .fillBurst(fillBurst), .hit(hit), .fillAddr(fillAddr),
    .respData(respData)
  );

endmodule

// File: rtl/xipc_checker.sv
module xipc_checker #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushReq,
  input logic              reqValid,
  input logic              reqReady,
  input logic              respValid,
  input logic              respErr,
  input logic              fillReq,
  input logic              fillBurst,
  input logic [ADDR_W-1:0] fillAddr
);
  localparam int OFF_BITS  = $clog2(LINE_BYTES);
  localparam int BYTE_BITS = $clog2(DATA_W / 8);

  assert_fill_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |=> !fillReq);

  assert_fill_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && fillBurst) |-> (fillAddr[OFF_BITS-1:0] == '0));

  assert_fill_not_resp_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !respValid);

  assert_bypass_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !fillBurst) |-> (fillAddr[BYTE_BITS-1:0] == '0));

  assert_err_with_resp_R8: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> respValid);

  assert_flush_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !reqReady);

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

endmodule

bind xip_flash_cache xipc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
) u_checker (
  .clk(clk), .rstN(rstN), .flushReq(flushReq), .reqValid(reqValid),
  .reqReady(reqReady), .respValid(respValid), .respErr(respErr),
  .fillReq(fillReq), .fillBurst(fillBurst), .fillAddr(fillAddr)
);

// File: tb/xip_flash_cache_bench.sv
module xip_flash_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cacheEn = 1'b1, sramMode = 1'b0, flushReq = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, respValid, respErr, fillReq, fillBurst;
  logic [31:0] respData;
  logic [23:0] fillAddr;
  logic        fillDataValid = 1'b0;
  logic [31:0] fillData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xip_flash_cache u_xip_flash_cache (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .sramMode(sramMode),
    .flushReq(flushReq), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .respValid(respValid), .respData(respData), .respErr(respErr),
    .fillReq(fillReq), .fillBurst(fillBurst), .fillAddr(fillAddr),
    .fillDataValid(fillDataValid), .fillData(fillData)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Behavioural reference state
  bit          mValid [128][8];
  int          mTag   [128][8];
  bit          mTree  [128][7];
  logic [31:0] mSram  [int];

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] flashWord(input int wa);
    return (32'(wa) * 32'h0100_0193) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic int victimOf(input int s);
    int node, way;
    for (int w = 0; w < 8; w++) if (!mValid[s][w]) return w;
    node = 0; way = 0;
    for (int l = 0; l < 3; l++) begin
      way  = way * 2 + int'(mTree[s][node]);
      node = 2 * node + 1 + int'(mTree[s][node]);
    end
    return way;
  endfunction

  function automatic void touch(input int s, input int w);
    int node, b;
    node = 0;
    for (int l = 0; l < 3; l++) begin
      b = (w >> (2 - l)) & 1;
      mTree[s][node] = (b == 0);
      node = 2 * node + 1 + b;
    end
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WDOG_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic setMode(input bit en, input bit sram);
    @(negedge clk);
    cacheEn  = en;
    sramMode = sram;
  endtask

  task automatic access(input bit wr, input logic [23:0] a, input logic [31:0] wd,
                        input string rq, input bit gaps, input bit flushMid);
    int guard, s, t, hw, v, nw, base;
    bit isHit, bypass;
    logic [31:0] exp;
    @(negedge clk);
    guard = 0;
    while (!reqReady && guard < 1000) begin @(negedge clk); guard++; end
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    chk(reqReady == 1'b0, {rq, " R10 ready low while busy"}, 32'(reqReady), 0);
    s = int'(a[11:5]); t = int'(a[23:12]);
    if (sramMode) begin
      @(negedge clk);
      chk(respValid && !respErr && !fillReq, {rq, " R7 scratch response"},
          {29'd0, respValid, respErr, fillReq}, 32'h4);
      if (wr) begin
        mSram[int'(a[14:2])] = wd;
        chk(respData == 0, {rq, " R7 write data zero"}, respData, 0);
      end else begin
        exp = mSram[int'(a[14:2])];
        chk(respData == exp, {rq, " R7 scratch read"}, respData, exp);
      end
    end else if (wr) begin
      @(negedge clk);
      chk(respValid && respErr && !fillReq, {rq, " R8 write rejected"},
          {29'd0, respValid, respErr, fillReq}, 32'h6);
      chk(respData == 0, {rq, " R8 error data"}, respData, 0);
    end else begin
      bypass = !cacheEn;
      isHit = 0; hw = 0;
      for (int w = 0; w < 8; w++)
        if (mValid[s][w] && mTag[s][w] == t) begin isHit = 1; hw = w; end
      exp = flashWord(int'(a >> 2));
      @(negedge clk);
      if (!bypass && isHit) begin
        chk(respValid && !fillReq, {rq, " hit response"},
            {30'd0, respValid, fillReq}, 32'h2);
        chk(respData == exp, {rq, " hit data"}, respData, exp);
        touch(s, hw);
      end else begin
        chk(fillReq && !respValid, {rq, " fill request"},
            {30'd0, fillReq, respValid}, 32'h2);
        chk(fillBurst == !bypass, {rq, " fill kind"}, 32'(fillBurst), 32'(!bypass));
        if (bypass) begin
          chk(fillAddr == {a[23:2], 2'b00}, {rq, " R6 word address"}, 32'(fillAddr),
              32'({a[23:2], 2'b00}));
          nw = 1; base = int'(a >> 2);
        end else begin
          chk(fillAddr == {a[23:5], 5'd0}, {rq, " R3 line address"}, 32'(fillAddr),
              32'({a[23:5], 5'd0}));
          nw = 8; base = int'(a >> 5) * 8;
        end
        for (int k = 0; k < nw; k++) begin
          if (gaps) @(negedge clk);
          fillDataValid = 1'b1;
          fillData = flashWord(base + k);
          if (flushMid && k == 3) flushReq = 1'b1;
          @(negedge clk);
          fillDataValid = 1'b0;
          flushReq = 1'b0;
        end
        chk(respValid == 1'b1, {rq, " fill response"}, 32'(respValid), 1);
        chk(respData == exp, {rq, " fill data"}, respData, exp);
        if (flushMid)
          chk(reqReady == 1'b0, {rq, " R9 flush waits for fill"}, 32'(reqReady), 0);
        if (!bypass) begin
          v = victimOf(s);
          mValid[s][v] = 1; mTag[s][v] = t;
          touch(s, v);
        end
      end
    end
  endtask

  task automatic waitFlushDone();
    int low;
    low = 0;
    while (!reqReady && low < 400) begin low++; @(negedge clk); end
    chk(low >= 1 && low <= 130, "R9 flush hold window", 32'(low), 129);
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 8; w++) mValid[s][w] = 0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    waitFlushDone();
  endtask

  function automatic logic [23:0] setAddr(input int tg, input int st, input int off);
    return {12'(tg), 7'(st), 5'(off)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 ready after reset", 32'(reqReady), 1);
    chk(respValid == 1'b0 && fillReq == 1'b0, "R1 idle outputs",
        {30'd0, respValid, fillReq}, 0);

    // R1/R3 first read misses, R2 second read of same line hits
    access(0, 24'h001234, 0, "R1 R3 first", 0, 0);
    access(0, 24'h001238, 0, "R2 same line", 0, 0);
    access(0, 24'h00123C, 0, "R2 last word", 0, 0);
    access(0, 24'hABC004, 0, "R3 gapped", 1, 0);

    // R4 eight tags in set 0x11, all stay resident
    for (int tg = 1; tg <= 8; tg++) access(0, setAddr(tg, 17, tg * 4 % 32), 0, "R4 fill", tg[0], 0);
    for (int tg = 1; tg <= 8; tg++) access(0, setAddr(tg, 17, 0), 0, "R4 resident", 0, 0);

    // R5 replacement order under a mixed pattern
    access(0, setAddr(3, 17, 8), 0, "R5 touch", 0, 0);
    access(0, setAddr(6, 17, 8), 0, "R5 touch", 0, 0);
    for (int tg = 9; tg <= 12; tg++) access(0, setAddr(tg, 17, 12), 0, "R5 evict", 0, 0);
    for (int tg = 1; tg <= 12; tg++) access(0, setAddr(tg, 17, 20), 0, "R5 reread", 0, 0);
    for (int tg = 12; tg >= 1; tg--) access(0, setAddr(tg, 17, 28), 0, "R5 reverse", 1, 0);

    // R8 writes ignored in cache and bypass modes
    access(1, 24'h001234, 32'hDEAD_BEEF, "R8 cache write", 0, 0);
    access(0, 24'h001234, 0, "R8 line intact", 0, 0);

    // R6 bypass of a resident line, then it still hits
    setMode(0, 0);
    access(0, 24'h00123E, 0, "R6 bypass", 0, 0);
    access(0, 24'h777770, 0, "R6 bypass uncached", 1, 0);
    access(1, 24'h001234, 32'h1111_2222, "R8 bypass write", 0, 0);
    setMode(1, 0);
    access(0, 24'h001230, 0, "R6 untouched", 0, 0);

    // R7 scratch memory mode, with upper address bits ignored
    setMode(1, 1);
    access(1, 24'h000104, 32'hCAFE_0104, "R7 wr", 0, 0);
    access(1, 24'h007FFC, 32'h0BAD_7FFC, "R7 wr top", 0, 0);
    access(1, 24'h000000, 32'h1234_5678, "R7 wr base", 0, 0);
    access(0, 24'h000104, 0, "R7 rd", 0, 0);
    access(0, 24'h008104, 0, "R7 alias", 0, 0);
    access(0, 24'h007FFC, 0, "R7 rd top", 0, 0);
    access(0, 24'hFF8000, 0, "R7 rd base alias", 0, 0);
    setMode(1, 0);

    // R9 flush clears everything
    doFlush();
    access(0, 24'h001234, 0, "R9 miss after flush", 0, 0);
    access(0, setAddr(5, 17, 0), 0, "R9 miss after flush", 0, 0);
    access(0, 24'h001234, 0, "R9 refilled hit", 0, 0);

    // R9 flush raised in the middle of a fill
    access(0, 24'h456780, 0, "R9 flush mid fill", 0, 1);
    waitFlushDone();
    access(0, 24'h456780, 0, "R9 miss after mid flush", 1, 0);
    access(0, 24'h456784, 0, "R2 after refill", 0, 0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule